// File: doc/BRIEF.md
# Throttle Pulse Sequencer for a Brushless Speed Controller

This block drives the command input of a hobby brushless motor speed controller with a servo-style pulse train. Every frame carries one high pulse whose width encodes an 8-bit throttle value. Neutral gives the shortest width and full throttle gives the longest. Widths in between scale linearly.

A speed controller accepts throttle commands only after it has seen neutral for some time. A heavily loaded rotor also tends to stall at low settings, and it draws too much current when asked to jump straight to a high speed. For these reasons the block runs a fixed start-up sequence after enable:

- An arming interval at neutral.
- A short, bounded kick at a fixed high throttle, so the rotor breaks away.
- A ramp that moves toward the requested target by at most one step per frame, in either direction.

A status code reports where the sequence stands. Dropping enable or applying reset returns the block to idle. In idle it keeps emitting neutral pulses, and the full sequence must run again before the next start.

Top module: `esc_throttle_seq`

## Requirements
- R1: The output repeats with a period of FRAME_US ticks (1 tick = CLK_HZ/TICK_HZ clock cycles, 1 µs at default). Each frame starts with exactly one high pulse and ends low.
- R2: The pulse lasts MIN_US + floor(level*SPAN_US/255) ticks, where level is the throttle value in force for that frame: 1000 µs at level 0 and 2000 µs at level 255 by default.
- R3: If the block is idle and enable is high at a frame boundary, the next ARM_FRAMES frames carry level 0 and status 1 (arming).
- R4: After arming, KICK_FRAMES frames carry level KICK_LEVEL (default 178, about 70 %) with status 2.
- R5: After the kick, the level changes at each frame boundary by exactly one step toward the target sampled at that boundary, and is unchanged once equal. No larger jump occurs.
- R6: During tracking, status is 3 (ramping) while the level differs from target_i and 4 (running) when they are equal. Idle reports status 0.
- R7: The target and the pulse width are taken only at frame boundaries. A target change or an enable drop during a pulse leaves that pulse's width unaltered.
- R8: With enable low, status reads 0 from the next clock cycle on. Frames from the next boundary onward carry level 0. Raising enable again restarts the sequence at R3.
- R9: During and after reset, status is 0 and a neutral-width frame begins at reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run request; low forces idle |
| target_i | input | 8 | Requested throttle, 0 = neutral, 255 = full |
| pulse_o | output | 1 | Throttle pulse line |
| status_o | output | 3 | 0 idle, 1 arming, 2 kick, 3 ramping, 4 running |

## Verification
Each result is due at a different time:

- The status code follows an enable drop one clock later.
- A new level and its pulse width appear only at the next frame boundary. A pulse is high for width×tick-divider cycles from the boundary edge, and the frame repeats every FRAME_US×divider cycles.
- The ramp advances by one level per frame.

The bench therefore measures whole frames on falling clock edges and checks each frame's high time and period against a frame-by-frame model. It changes the target and enable only after the pulse of interest has begun or ended, so every check lands on the frame the requirements assign it to.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_KICK = 3'd2,
    ST_RAMP = 3'd3,
    ST_RUN  = 3'd4
  } seq_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARM,
    PH_KICK,
    PH_TRACK
  } seq_phase_e;

  // Pulse width in ticks for a throttle level: base plus linear span, floored.
  function automatic int unsigned pulse_ticks(input logic [7:0] level,
                                              input int unsigned min_t,
                                              input int unsigned span_t);
    return min_t + (32'(level) * span_t) / 32'd255;
  endfunction

  // One bounded step of the level toward the goal.
  function automatic logic [7:0] step_toward(input logic [7:0] cur,
                                             input logic [7:0] goal);
    if (cur < goal)      return cur + 8'd1;
    else if (cur > goal) return cur - 8'd1;
    else                 return cur;
  endfunction

endpackage

// File: rtl/esc_tick_gen.sv
module esc_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
        if (rst_i)                       cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end else begin : g_pass
      logic unused_in;
      assign unused_in = clk_i ^ rst_i;
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/esc_frame_timer.sv
module esc_frame_timer #(
  parameter int unsigned FRAME_US = 20000,
  localparam int unsigned UW = $clog2(FRAME_US)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  output logic [UW-1:0] pos_o,
  output logic          frame_end_o
);
  logic last_pos;
  assign last_pos    = (pos_o == UW'(FRAME_US - 1));
  assign frame_end_o = tick_i && last_pos;

  always_ff @(posedge clk_i) begin
    if (rst_i)        pos_o <= '0;
    else if (tick_i)  pos_o <= last_pos ? '0 : pos_o + 1'b1;
  end
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_seq_pkg::*;
#(
  parameter int unsigned ARM_FRAMES  = 100,
  parameter int unsigned KICK_FRAMES = 25,
  parameter int unsigned KICK_LEVEL  = 178,
  localparam int unsigned MAXF = (ARM_FRAMES > KICK_FRAMES) ? ARM_FRAMES : KICK_FRAMES,
  localparam int unsigned CW   = $clog2(MAXF + 1)
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic       frame_end_i,
  input  logic [7:0] target_i,
  output seq_phase_e phase_o,
  output logic [7:0] level_o,
  output logic [7:0] level_nxt_o
);
  seq_phase_e    phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    level_d;

  always_comb begin
    phase_d = phase_o;
    cnt_d   = cnt_q;
    level_d = level_o;
    if (!en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      level_d = 8'd0;
    end else if (frame_end_i) begin
      case (phase_o)
        PH_IDLE: begin
          phase_d = PH_ARM;
          cnt_d   = CW'(1);
          level_d = 8'd0;
        end
        PH_ARM: begin
          if (cnt_q == CW'(ARM_FRAMES)) begin
            phase_d = PH_KICK;
            cnt_d   = CW'(1);
            level_d = 8'(KICK_LEVEL);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_KICK: begin
          if (cnt_q == CW'(KICK_FRAMES)) begin
            phase_d = PH_TRACK;
            cnt_d   = '0;
            level_d = step_toward(level_o, target_i);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: level_d = step_toward(level_o, target_i);
      endcase
    end
  end

  assign level_nxt_o = level_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
      level_o <= 8'd0;
    end else begin
      phase_o <= phase_d;
      cnt_q   <= cnt_d;
      level_o <= level_d;
    end
  end
endmodule

// File: rtl/esc_pulse_gen.sv
module esc_pulse_gen
  import esc_seq_pkg::*;
#(
  parameter int unsigned FRAME_US = 20000,
  parameter int unsigned MIN_US   = 1000,
  parameter int unsigned SPAN_US  = 1000,
  localparam int unsigned UW = $clog2(FRAME_US)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          frame_end_i,
  input  logic [7:0]    level_nxt_i,
  input  logic [UW-1:0] pos_i,
  output logic [UW-1:0] width_o,
  output logic          pulse_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)            width_o <= UW'(MIN_US);
    else if (frame_end_i) width_o <= UW'(pulse_ticks(level_nxt_i, MIN_US, SPAN_US));
  end

  assign pulse_o = (pos_i < width_o);
endmodule

// File: rtl/esc_throttle_seq.sv
module esc_throttle_seq
  import esc_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TICK_HZ     = 1_000_000,
  parameter int unsigned FRAME_US    = 20000,
  parameter int unsigned MIN_US      = 1000,
  parameter int unsigned SPAN_US     = 1000,
  parameter int unsigned ARM_FRAMES  = 100,
  parameter int unsigned KICK_FRAMES = 25,
  parameter int unsigned KICK_LEVEL  = 178
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic [7:0] target_i,
  output logic       pulse_o,
  output logic [2:0] status_o
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;
  localparam int unsigned UW  = $clog2(FRAME_US);

  logic          tick;
  logic          frame_end;
  logic [UW-1:0] pos;
  logic [UW-1:0] width_q;
  logic [7:0]    level_q;
  logic [7:0]    level_nxt;
  seq_phase_e    phase;

  esc_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick)
  );

  esc_frame_timer #(.FRAME_US(FRAME_US)) u_frame (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
    .pos_o(pos), .frame_end_o(frame_end)
  );

  esc_seq_fsm #(
    .ARM_FRAMES(ARM_FRAMES), .KICK_FRAMES(KICK_FRAMES), .KICK_LEVEL(KICK_LEVEL)
  ) u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .frame_end_i(frame_end),
    .target_i(target_i), .phase_o(phase), .level_o(level_q), .level_nxt_o(level_nxt)
  );

  esc_pulse_gen #(
    .FRAME_US(FRAME_US), .MIN_US(MIN_US), .SPAN_US(SPAN_US)
  ) u_pulse (
    .clk_i(clk_i), .rst_i(rst_i), .frame_end_i(frame_end),
    .level_nxt_i(level_nxt), .pos_i(pos), .width_o(width_q), .pulse_o(pulse_o)
  );

  always_comb begin
    case (phase)
      PH_ARM:   status_o = ST_ARM;
      PH_KICK:  status_o = ST_KICK;
      PH_TRACK: status_o = (level_q == target_i) ? ST_RUN : ST_RAMP;
      default:  status_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/esc_seq_chk.sv
module esc_seq_chk #(
  parameter int unsigned MIN_US     = 1000,
  parameter int unsigned KICK_LEVEL = 178,
  parameter int unsigned UW         = 15
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          en_i,
  input logic          frame_end,
  input logic          pulse_o,
  input logic [2:0]    status_o,
  input logic [7:0]    level_q,
  input logic [UW-1:0] width_q
);
  // R1
  pulse_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pulse_o) |-> $past(frame_end));

  // R2
  arm_neutral_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o == 3'd1) |-> (width_q == UW'(MIN_US)));

  // R3
  kick_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o == 3'd2 && $past(status_o) != 3'd2) |-> ($past(status_o) == 3'd1));

  // R4
  kick_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o == 3'd2) |-> (level_q == 8'(KICK_LEVEL)));

  // R5
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_end && en_i && status_o >= 3'd3) |=>
      (level_q == $past(level_q) || level_q == $past(level_q) + 8'd1 ||
       level_q == $past(level_q) - 8'd1));

  // R7
  width_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !frame_end |=> $stable(width_q));

  // R8
  idle_on_disable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (status_o == 3'd0));
endmodule

bind esc_throttle_seq esc_seq_chk #(
  .MIN_US(MIN_US), .KICK_LEVEL(KICK_LEVEL), .UW(UW)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .frame_end(frame_end),
  .pulse_o(pulse_o), .status_o(status_o), .level_q(level_q), .width_q(width_q)
);

// File: tb/esc_throttle_seq_test.sv
module esc_throttle_seq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIVC  = 2;     // clock cycles per tick (200 MHz / 100 MHz)
  localparam int FR    = 32;    // ticks per frame
  localparam int MINW  = 8;
  localparam int SPANW = 16;
  localparam int NARM  = 4;
  localparam int NKICK = 3;
  localparam int KLVL  = 178;
  localparam int PER   = FR * DIVC;

  // target, frames to run
  localparam int VEC [6][2] = '{'{170, 12}, '{175, 8}, '{175, 3},
                                '{255, 85}, '{250, 8}, '{0, 4}};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b1;
  logic [7:0] target = 8'd40;
  logic       pulse;
  logic [2:0] status;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  esc_throttle_seq #(
    .CLK_HZ(200_000_000), .TICK_HZ(100_000_000), .FRAME_US(FR),
    .MIN_US(MINW), .SPAN_US(SPANW), .ARM_FRAMES(NARM),
    .KICK_FRAMES(NKICK), .KICK_LEVEL(KLVL)
  ) uut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .target_i(target),
    .pulse_o(pulse), .status_o(status)
  );

  // Frame monitor on falling edges
  int  hi_cnt, per_cnt, last_hi, last_per, rises;
  bit  prev;
  event rise_ev, fall_ev;

  always @(negedge clk) begin
    if (rst) begin
      hi_cnt = 0; per_cnt = 0; prev = 1'b1; rises = 0;
    end else begin
      if (pulse && !prev) begin
        last_per = per_cnt; per_cnt = 1; hi_cnt = 1; rises++;
        ->rise_ev;
      end else begin
        per_cnt++;
        if (pulse) hi_cnt++;
      end
      if (!pulse && prev) begin
        last_hi = hi_cnt;
        ->fall_ev;
      end
      prev = pulse;
    end
  end

  function automatic int exp_hi(input int lvl);
    int prod = lvl * SPANW;
    return (MINW + (prod - prod % 255) / 255) * DIVC;
  endfunction

  function automatic int nxt(input int lvl, input int goal);
    if (goal > lvl) return lvl + 1;
    if (goal < lvl) return lvl - 1;
    return lvl;
  endfunction

  task automatic frame_check(input int lvl, input int st, input string req);
    @(fall_ev);
    n_vec++;
    if (last_hi != exp_hi(lvl) || int'(status) != st) begin
      n_bad++;
      $display("FAIL %s: high=%0d status=%0d, expected high=%0d status=%0d",
               req, last_hi, status, exp_hi(lvl), st);
    end
    if (rises >= 2) begin
      n_vec++;
      if (last_per != PER) begin
        n_bad++;
        $display("FAIL R1: period=%0d, expected %0d", last_per, PER);
      end
    end
  endtask

  task automatic simple_check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int lvl;
    repeat (5) @(negedge clk);
    // R9: reset state
    simple_check(status == 3'd0, "R9 status in reset", int'(status), 0);
    simple_check(pulse == 1'b1, "R9 pulse in reset", int'(pulse), 1);
    rst = 1'b0;

    @(fall_ev);
    simple_check(status == 3'd0, "R9 idle first frame", int'(status), 0);

    for (int f = 0; f < NARM; f++) frame_check(0, 1, "R3 arm");
    for (int f = 0; f < NKICK; f++) frame_check(KLVL, 2, "R4 kick");

    lvl = KLVL;
    for (int i = 0; i < 6; i++) begin
      target = 8'(VEC[i][0]);
      for (int f = 0; f < VEC[i][1]; f++) begin
        lvl = nxt(lvl, VEC[i][0]);
        frame_check(lvl, (lvl == VEC[i][0]) ? 4 : 3, "R2 R5 R6 ramp");
      end
    end

    // R7: target change during a pulse does not alter it
    @(rise_ev);
    repeat (3) @(negedge clk);
    target = 8'd255;
    lvl = nxt(lvl, 0);
    frame_check(lvl, 3, "R7 mid-pulse target");

    // R8: enable drop mid-pulse
    @(rise_ev);
    repeat (2) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    simple_check(status == 3'd0, "R8 status after disable", int'(status), 0);
    lvl = nxt(lvl, 255);
    frame_check(lvl, 0, "R7 R8 pulse kept");
    frame_check(0, 0, "R8 idle neutral");
    frame_check(0, 0, "R8 idle neutral");
    en = 1'b1;
    for (int f = 0; f < NARM; f++) frame_check(0, 1, "R8 R3 re-arm");
    for (int f = 0; f < NKICK; f++) frame_check(KLVL, 2, "R8 R4 re-kick");
    frame_check(KLVL + 1, 3, "R5 first ramp step");

    // R9: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    simple_check(status == 3'd0, "R9 status on reset", int'(status), 0);
    simple_check(pulse == 1'b1, "R9 neutral frame start", int'(pulse), 1);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule